// File: doc/BRIEF.md
# Two-Pass Integrating ADC Sequencer

This block is the synchronous control core of a two-pass integrating analog-to-digital converter. It drives the analog switches around an external integrator and comparator, and it gates an external result counter. The integrator, the comparator, the counter and the arithmetic that merges the two counts all sit outside the block.

A coarse pass opens on a rising edge of the start input. The measured input is integrated for a fixed window of `T1` clocks. The opposite-polarity full reference is then connected, and the counter is gated on until the comparator crosses zero. The fine pass opens only when the start input and the fine request rise on the same clock. Its fixed window is `M_FACTOR` times longer. In each `T1` sub-interval a feedback strobe is pulsed low for a programmable number of clocks, so that reference charge matching the coarse result is fed back. De-integration then runs on a reduced reference to resolve the low-order digits.

The comparator input passes through a two-flop synchronizer. The controller clock must run at more than twice the counter clock.

Top module: `adc2p_seq`

## Requirements
- R1: While reset is asserted and right after it, the switch outputs (`conn_in_o`, `ref_neg_o`, `ref_pos_o`, `ref_lo_neg_o`, `ref_lo_pos_o`), `count_en_o` and `sign_o` are 0. `tint_no`, `fb_no`, `irq_no` and `discharge_o` are 1.
- R2: In the idle or rest state, a rising edge on `start_i` opens a window on the next clock. During the window `conn_in_o` is 1 and `tint_no` is 0. When `fine_req_i` did not also rise, the window lasts exactly `T1` clocks.
- R3: A fine pass begins only when `start_i` and `fine_req_i` rise on the same clock. Its window lasts exactly `T1*M_FACTOR` clocks. A `fine_req_i` that is already high when `start_i` rises gives a coarse pass.
- R4: During a fine window, `fb_no` is 0 for the first `fb_len_i` clocks of every `T1`-clock sub-interval and 1 for the rest of that sub-interval. `fb_no` is always 1 outside fine windows.
- R5: When the window closes, `conn_in_o` drops and `sign_o` latches the synchronized comparator bit (0 = positive input, 1 = negative input). In a coarse pass, de-integration connects `ref_neg_o` when `sign_o`=0 and `ref_pos_o` when `sign_o`=1.
- R6: In a fine pass, de-integration connects `ref_lo_neg_o` when `sign_o`=0 and `ref_lo_pos_o` when `sign_o`=1. Both full references stay off.
- R7: `count_en_o` is 1 for the whole de-integration phase and 0 at all other times. The phase ends on the third rising clock edge after `cmp_i` changes away from the latched sign.
- R8: `irq_no` goes to 0 on the clock that ends de-integration and stays 0 in the rest state. It returns to 1 when the next pass starts. `discharge_o` is 1 exactly in the idle and rest states.
- R9: A rising edge on `start_i` while a pass is in progress is ignored. The window length and the phase sequence stay unchanged.
- R10: At most one of `conn_in_o`, `ref_neg_o`, `ref_pos_o`, `ref_lo_neg_o`, `ref_lo_pos_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start; acts on its rising edge |
| fine_req_i | input | 1 | Fine-pass request; must rise together with `start_i` |
| cmp_i | input | 1 | Comparator bit, 0 = positive, 1 = negative (asynchronous) |
| fb_len_i | input | $clog2(T1+1) | Feedback strobe length per sub-interval, in clocks |
| conn_in_o | output | 1 | Connect the measured input to the integrator |
| ref_neg_o | output | 1 | Connect the full negative reference |
| ref_pos_o | output | 1 | Connect the full positive reference |
| ref_lo_neg_o | output | 1 | Connect the reduced negative reference |
| ref_lo_pos_o | output | 1 | Connect the reduced positive reference |
| discharge_o | output | 1 | Integrator discharge switch (idle and rest) |
| tint_no | output | 1 | Fixed-window strobe, active low |
| fb_no | output | 1 | Feedback strobe, active low |
| count_en_o | output | 1 | Counter gate during de-integration |
| sign_o | output | 1 | Latched polarity, 0 = positive |
| irq_no | output | 1 | End-of-pass interrupt, falls at the end of a pass |

## Verification
The bench targets the following corner cases:
- A start edge arriving in the middle of a window. A design that restarted would stretch the window beyond `T1`.
- A fine request that is held high instead of rising. A design that decoded the level would run a window `M_FACTOR` times too long.
- Feedback lengths of 0, 1, `T1-1` and `T1`. An off-by-one in the sub-interval compare shows up as a strobe one clock too long or too short.
- De-integration spans as short as one clock, for both polarities and both passes. These pin down the synchronizer latency and the reference selection, which a missing flop or a swapped reference breaks.
- A reset applied mid-window, which must drop every switch at once.

// File: rtl/adc2p_pkg.sv
package adc2p_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DEINT = 2'd2,
    ST_REST  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc2p_sync.sv
module adc2p_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc2p_edge.sv
module adc2p_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/adc2p_timer.sv
module adc2p_timer #(
  parameter int T1       = 8,
  parameter int M_FACTOR = 10,
  localparam int TW      = $clog2(T1*M_FACTOR+1),
  localparam int SW      = $clog2(T1+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] last_i,
  output logic          done_o,
  output logic [SW-1:0] sub_o
);
  localparam logic [SW-1:0] SUB_LAST = SW'(T1-1);

  logic [TW-1:0] cnt_q;
  logic [SW-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (!run_i || done_o) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == last_i);
  assign sub_o  = sub_q;
endmodule

// File: rtl/adc2p_seq.sv
module adc2p_seq #(
  parameter int T1       = 8,
  parameter int M_FACTOR = 10,
  localparam int TW      = $clog2(T1*M_FACTOR+1),
  localparam int SW      = $clog2(T1+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fine_req_i,
  input  logic          cmp_i,
  input  logic [SW-1:0] fb_len_i,
  output logic          conn_in_o,
  output logic          ref_neg_o,
  output logic          ref_pos_o,
  output logic          ref_lo_neg_o,
  output logic          ref_lo_pos_o,
  output logic          discharge_o,
  output logic          tint_no,
  output logic          fb_no,
  output logic          count_en_o,
  output logic          sign_o,
  output logic          irq_no
);
  import adc2p_pkg::*;

  localparam logic [TW-1:0] COARSE_LAST = TW'(T1-1);
  localparam logic [TW-1:0] FINE_LAST   = TW'(T1*M_FACTOR-1);

  seq_state_e    state_q, state_d;
  logic          fine_q, fine_d;
  logic          sign_q, sign_d;
  logic          irq_nq, irq_nd;
  logic          cmp_s;
  logic [1:0]    rise;
  logic          tmr_done;
  logic [SW-1:0] sub;
  logic          in_integ, in_deint, resting;

  adc2p_sync #(.STAGES(2)) u_cmp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  adc2p_edge #(.N(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({fine_req_i, start_i}),
    .rise_o(rise)
  );

  adc2p_timer #(.T1(T1), .M_FACTOR(M_FACTOR)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (in_integ),
    .last_i(fine_q ? FINE_LAST : COARSE_LAST),
    .done_o(tmr_done),
    .sub_o (sub)
  );

  assign in_integ = (state_q == ST_INTEG);
  assign in_deint = (state_q == ST_DEINT);
  assign resting  = (state_q == ST_IDLE) || (state_q == ST_REST);

  always_comb begin
    state_d = state_q;
    fine_d  = fine_q;
    sign_d  = sign_q;
    irq_nd  = irq_nq;
    unique case (state_q)
      ST_IDLE, ST_REST: begin
        if (rise[0]) begin
          state_d = ST_INTEG;
          fine_d  = rise[1];
          irq_nd  = 1'b1;
        end
      end
      ST_INTEG: begin
        if (tmr_done) begin
          state_d = ST_DEINT;
          sign_d  = cmp_s;
        end
      end
      ST_DEINT: begin
        // zero crossing: comparator left the latched polarity
        if (cmp_s != sign_q) begin
          state_d = ST_REST;
          irq_nd  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fine_q  <= 1'b0;
      sign_q  <= 1'b0;
      irq_nq  <= 1'b1;
    end else begin
      state_q <= state_d;
      fine_q  <= fine_d;
      sign_q  <= sign_d;
      irq_nq  <= irq_nd;
    end
  end

  assign conn_in_o    = in_integ;
  assign tint_no      = ~in_integ;
  assign fb_no        = ~(in_integ && fine_q && (sub < fb_len_i));
  assign ref_neg_o    = in_deint && !fine_q && !sign_q;
  assign ref_pos_o    = in_deint && !fine_q &&  sign_q;
  assign ref_lo_neg_o = in_deint &&  fine_q && !sign_q;
  assign ref_lo_pos_o = in_deint &&  fine_q &&  sign_q;
  assign count_en_o   = in_deint;
  assign discharge_o  = resting;
  assign sign_o       = sign_q;
  assign irq_no       = irq_nq;
endmodule

// File: rtl/adc2p_seq_chk.sv
module adc2p_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic conn_in_o,
  input logic ref_neg_o,
  input logic ref_pos_o,
  input logic ref_lo_neg_o,
  input logic ref_lo_pos_o,
  input logic discharge_o,
  input logic tint_no,
  input logic fb_no,
  input logic count_en_o,
  input logic irq_no
);
  AST_ONE_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conn_in_o, ref_neg_o, ref_pos_o, ref_lo_neg_o, ref_lo_pos_o})); // R10

  AST_START_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discharge_o && $rose(start_i)) |=> (!tint_no && irq_no)); // R2

  AST_FB_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_no |-> !tint_no); // R4

  AST_DEINT_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(count_en_o) |-> $fell(conn_in_o)); // R5

  AST_COUNT_GATED_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_o |-> $countones({ref_neg_o, ref_pos_o, ref_lo_neg_o, ref_lo_pos_o}) == 1); // R7

  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(count_en_o) |-> (!irq_no && discharge_o)); // R8

  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && $rose(start_i)) |=> (tint_no && !conn_in_o)); // R9
endmodule

bind adc2p_seq adc2p_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .conn_in_o   (conn_in_o),
  .ref_neg_o   (ref_neg_o),
  .ref_pos_o   (ref_pos_o),
  .ref_lo_neg_o(ref_lo_neg_o),
  .ref_lo_pos_o(ref_lo_pos_o),
  .discharge_o (discharge_o),
  .tint_no     (tint_no),
  .fb_no       (fb_no),
  .count_en_o  (count_en_o),
  .irq_no      (irq_no)
);

// File: tb/sim_adc2p_seq.sv
`timescale 1ns/1ps
module sim_adc2p_seq;
  localparam int T1 = 5;
  localparam int MF = 3;
  localparam int SW = $clog2(T1+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, fine_req = 1'b0, cmp = 1'b0;
  logic [SW-1:0] fb_len = '0;
  logic conn_in, ref_neg, ref_pos, ref_lo_neg, ref_lo_pos, discharge;
  logic tint_n, fb_n, count_en, sign, irq_n;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc2p_seq #(.T1(T1), .M_FACTOR(MF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fine_req_i(fine_req),
    .cmp_i(cmp), .fb_len_i(fb_len), .conn_in_o(conn_in), .ref_neg_o(ref_neg),
    .ref_pos_o(ref_pos), .ref_lo_neg_o(ref_lo_neg), .ref_lo_pos_o(ref_lo_pos),
    .discharge_o(discharge), .tint_no(tint_n), .fb_no(fb_n),
    .count_en_o(count_en), .sign_o(sign), .irq_no(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk({conn_in, ref_neg, ref_pos, ref_lo_neg, ref_lo_pos, count_en, sign} == 7'b0,
        tag, {conn_in, ref_neg, ref_pos, ref_lo_neg, ref_lo_pos, count_en, sign}, 0);
    chk({tint_n, fb_n, irq_n, discharge} == 4'hF, tag, {tint_n, fb_n, irq_n, discharge}, 15);
  endtask

  // fine: {exp_fine, sign, fb_len[2:0], dlen[3:0], glitch}
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 4'd4, 1'b0},
    {1'b0, 1'b1, 3'd0, 4'd1, 1'b0},
    {1'b1, 1'b0, 3'd2, 4'd6, 1'b0},
    {1'b1, 1'b1, 3'd1, 4'd2, 1'b0},
    {1'b1, 1'b0, 3'd5, 4'd1, 1'b0},
    {1'b1, 1'b1, 3'd4, 4'd3, 1'b1},
    {1'b0, 1'b1, 3'd0, 4'd7, 1'b1}
  };

  task automatic run_pass(input bit exp_fine, input bit drv_fine, input bit sgn,
                          input int fbl, input int dlen, input bit glitch);
    int w, n, fb_bad, guard;
    bit exp_fb;
    w = exp_fine ? T1*MF : T1;
    cmp = sgn;
    fb_len = SW'(fbl);
    repeat (3) @(negedge clk);
    start = 1'b1;
    if (drv_fine) fine_req = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (drv_fine) fine_req = 1'b0;
    chk(irq_n == 1'b1, "R8 irq high on new pass", irq_n, 1);
    n = 0; fb_bad = 0; guard = 0;
    while (!tint_n && guard < 1000) begin
      if (!conn_in) fb_bad++;
      exp_fb = !(exp_fine && ((n % T1) < fbl));
      if (fb_n != exp_fb) fb_bad++;
      if (glitch && n == 2) start = 1'b1;
      if (glitch && n == 3) start = 1'b0;
      n++; guard++;
      @(negedge clk);
    end
    chk(n == w, exp_fine ? "R3 fine window length" : (glitch ? "R9 window with start glitch" : "R2 coarse window length"), n, w);
    chk(fb_bad == 0, "R4 feedback strobe pattern", fb_bad, 0);
    chk(sign == sgn, "R5 latched polarity", sign, sgn);
    chk(conn_in == 1'b0, "R5 input released", conn_in, 0);
    if (exp_fine)
      chk({ref_neg, ref_pos, ref_lo_neg, ref_lo_pos} == (sgn ? 4'b0001 : 4'b0010),
          "R6 reduced reference select", {ref_neg, ref_pos, ref_lo_neg, ref_lo_pos}, sgn ? 1 : 2);
    else
      chk({ref_neg, ref_pos, ref_lo_neg, ref_lo_pos} == (sgn ? 4'b0100 : 4'b1000),
          "R5 full reference select", {ref_neg, ref_pos, ref_lo_neg, ref_lo_pos}, sgn ? 4 : 8);
    n = 0; guard = 0;
    while (count_en && guard < 1000) begin
      n++; guard++;
      if (glitch && n == 1) start = 1'b1;
      if (glitch && n == 2) start = 1'b0;
      if (n == dlen) cmp = ~cmp;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == dlen + 2, "R7 count gate span", n, dlen + 2);
    chk(irq_n == 1'b0 && discharge && tint_n, "R8 rest after pass", {irq_n, discharge, tint_n}, 3'b011);
    repeat (2) @(negedge clk);
    chk(tint_n && !count_en && !conn_in, "R9 no restart from busy start", {tint_n, count_en, conn_in}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("R1 state in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 state after reset");

    for (int i = 0; i < NV; i++) begin
      run_pass(VEC[i][9], VEC[i][9], VEC[i][8], int'(VEC[i][7:5]), int'(VEC[i][4:1]), VEC[i][0]);
    end

    // fine request held high beforehand: coarse pass expected (R3)
    fine_req = 1'b1;
    repeat (2) @(negedge clk);
    run_pass(1'b0, 1'b0, 1'b0, 3, 2, 1'b0);
    fine_req = 1'b0;

    // fine request rising alone does not start a pass (R3)
    @(negedge clk);
    fine_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(tint_n && discharge && !conn_in, "R3 fine request alone ignored", {tint_n, discharge, conn_in}, 3'b110);
    fine_req = 1'b0;

    // reset in the middle of a fine window (R1)
    cmp = 1'b0;
    fb_len = SW'(2);
    repeat (3) @(negedge clk);
    start = 1'b1; fine_req = 1'b1;
    @(negedge clk);
    start = 1'b0; fine_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tint_n, "R3 window open before reset", tint_n, 0);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R1 asynchronous reset mid-window");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 idle after reset release");

    run_pass(1'b0, 1'b0, 1'b1, 0, 3, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule